// File: doc/BRIEF.md
# ZQ Driver Code Load Unit

This unit moves calibrated pull-up and pull-down impedance codes into the registers that set the output drivers of a DRAM interface. A calibration engine elsewhere presents the codes; this block decides when they reach the drivers. Each driver register has a companion that holds the next-stronger code (code plus one), which saturates at the top of its range.

There are two ways to load. The refresh-timed path arms on a rising edge of a trigger and takes a snapshot of the codes and the target select. The snapshot is written into the drivers only when the next auto-refresh strobe arrives, so the impedance never changes while data is on the bus. The immediate path writes the presented code to the selected driver on the next clock edge. A select input chooses the target for both paths (0 for pull-up, 1 for pull-down), so a full update takes two loads. A calibration-enable input gates both paths. Dropping it cancels a pending load.

The control is a two-state machine. IDLE goes to ARMED on an enabled trigger edge (transition ARM). ARMED goes back to IDLE on a refresh strobe, after applying the snapshot (transition COMMIT), or when calibration-enable falls (transition CANCEL). ARMED stays in ARMED and re-snapshots on another enabled trigger edge (transition REARM).

Top module: `zq_code_loader`

## Requirements
- R1: After reset both applied codes are 0, both neighbour outputs are 1 and busy is 0.
- R2: A 0-to-1 change of `hw_trig` with `cal_en` and `hw_en` high raises `busy` on the next cycle. The driver outputs keep their values until a refresh strobe arrives, even if the code inputs change in the meantime.
- R3: Holding `hw_trig` high arms only once. After a load completes, no new load is armed until `hw_trig` has returned to 0 and risen again.
- R4: A `refresh_evt` while armed writes the snapshot code into the target taken at arming (select 0 = pull-up, 1 = pull-down) and lowers `busy` on the next cycle. The other target is unchanged.
- R5: A `refresh_evt` while not armed changes no output.
- R6: A new enabled trigger edge while armed replaces the snapshot with the current codes and select, and the unit stays armed.
- R7: With `cal_en`, `sw_en` and `sw_go` all high, the current code goes to the target chosen by `sel_pd` on the next clock edge, with no refresh needed. The other target is unchanged.
- R8: The immediate path does nothing unless both `sw_en` and `sw_go` are high.
- R9: Each neighbour output equals its applied code plus one, saturating at 2^W-1 (0x1F for the 5-bit pull-up, 0x0F for the 4-bit pull-down).
- R10: While `cal_en` is low, trigger edges and immediate loads are ignored, and a pending load is cancelled (busy falls next cycle and a later refresh applies nothing).
- R11: If an immediate load and a refresh-timed load hit the same target in the same cycle, the immediate load's code wins.
- R12: With `hw_en` low, a trigger edge does not arm a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_en | input | 1 | Calibration power enable; gates both paths |
| hw_en | input | 1 | Enables the refresh-timed path |
| hw_trig | input | 1 | Trigger; its rising edge arms a load |
| sw_en | input | 1 | Enables the immediate path |
| sw_go | input | 1 | Immediate load request |
| sel_pd | input | 1 | Target select: 0 pull-up, 1 pull-down |
| refresh_evt | input | 1 | Auto-refresh event strobe |
| pu_code | input | PU_W | Staged pull-up code |
| pd_code | input | PD_W | Staged pull-down code |
| pu_drv | output | PU_W | Applied pull-up code |
| pu_drv_nb | output | PU_W | Applied pull-up neighbour (saturating +1) |
| pd_drv | output | PD_W | Applied pull-down code |
| pd_drv_nb | output | PD_W | Applied pull-down neighbour (saturating +1) |
| busy | output | 1 | A refresh-timed load is pending |

## Verification
All outputs come from registers, so every result lands exactly one clock edge after the inputs that cause it. This covers `busy` after a trigger edge or a cancel, driver outputs after an immediate load, and driver outputs after a refresh strobe. The bench changes inputs just after a falling edge and reads outputs at the next falling edge, so each check sees the result of exactly one rising edge. Checks that something is held or ignored wait one or more further edges before reading, so that a late change would be seen.

// File: rtl/zq_load_pkg.sv
package zq_load_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } ld_state_e;

    localparam logic TGT_PU = 1'b0;
    localparam logic TGT_PD = 1'b1;
endpackage

// File: rtl/zq_rise_detect.sv
module zq_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;

    // R3: one edge per high phase
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/zq_snapshot.sv
module zq_snapshot #(
    parameter int PU_W = 5,
    parameter int PD_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            sel_in,
    input  logic [PU_W-1:0] pu_in,
    input  logic [PD_W-1:0] pd_in,
    output logic            sel_q,
    output logic [PU_W-1:0] pu_q,
    output logic [PD_W-1:0] pd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            pu_q  <= '0;
            pd_q  <= '0;
        end else if (capture) begin
            sel_q <= sel_in;
            pu_q  <= pu_in;
            pd_q  <= pd_in;
        end
    end

    // R6: snapshot moves only on capture
    p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(pu_q) && $stable(pd_q) && $stable(sel_q)));
endmodule

// File: rtl/zq_code_reg.sv
module zq_code_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_hw,
    input  logic [W-1:0] d_hw,
    input  logic         we_sw,
    input  logic [W-1:0] d_sw,
    output logic [W-1:0] code,
    output logic [W-1:0] code_nb
);
    localparam logic [W-1:0] CODE_MAX = '1;
    localparam logic [W-1:0] NB_RST   = W'(1);

    logic [W-1:0] code_d;
    logic [W-1:0] nb_d;
    logic         we;

    always_comb begin
        we     = we_hw | we_sw;
        code_d = we_sw ? d_sw : d_hw;
        nb_d   = (code_d == CODE_MAX) ? CODE_MAX : code_d + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code    <= '0;
            code_nb <= NB_RST;
        end else if (we) begin
            code    <= code_d;
            code_nb <= nb_d;
        end
    end

    // R9: neighbour is saturating code+1
    p_nb_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        code_nb == ((code == CODE_MAX) ? CODE_MAX : code + 1'b1));
    // R11: immediate write wins
    p_sw_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we_sw |=> code == $past(d_sw));
    // R2: no write, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_hw && !we_sw) |=> $stable(code));
endmodule

// File: rtl/zq_code_loader.sv
module zq_code_loader
    import zq_load_pkg::*;
#(
    parameter int PU_W = 5,
    parameter int PD_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cal_en,
    input  logic            hw_en,
    input  logic            hw_trig,
    input  logic            sw_en,
    input  logic            sw_go,
    input  logic            sel_pd,
    input  logic            refresh_evt,
    input  logic [PU_W-1:0] pu_code,
    input  logic [PD_W-1:0] pd_code,
    output logic [PU_W-1:0] pu_drv,
    output logic [PU_W-1:0] pu_drv_nb,
    output logic [PD_W-1:0] pd_drv,
    output logic [PD_W-1:0] pd_drv_nb,
    output logic            busy
);
    ld_state_e       state_q, state_d;
    logic            trig_rise;
    logic            arm_ok;
    logic            capture;
    logic            hw_apply;
    logic            sw_apply;
    logic            pend_sel;
    logic [PU_W-1:0] pend_pu;
    logic [PD_W-1:0] pend_pd;

    zq_rise_detect u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (hw_trig),
        .rise  (trig_rise)
    );

    zq_snapshot #(.PU_W(PU_W), .PD_W(PD_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .sel_in  (sel_pd),
        .pu_in   (pu_code),
        .pd_in   (pd_code),
        .sel_q   (pend_sel),
        .pu_q    (pend_pu),
        .pd_q    (pend_pd)
    );

    assign arm_ok   = cal_en & hw_en & trig_rise;
    assign sw_apply = cal_en & sw_en & sw_go;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: ARM, COMMIT, CANCEL, REARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_ok) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!cal_en)          state_d = ST_IDLE;
                else if (arm_ok)      state_d = ST_ARMED;
                else if (refresh_evt) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        busy     = 1'b0;
        capture  = 1'b0;
        hw_apply = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture = arm_ok;
            end
            ST_ARMED: begin
                busy     = 1'b1;
                capture  = arm_ok;
                hw_apply = cal_en & refresh_evt;
            end
            default: ;
        endcase
    end

    zq_code_reg #(.W(PU_W)) u_pu_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_hw   (hw_apply && (pend_sel == TGT_PU)),
        .d_hw    (pend_pu),
        .we_sw   (sw_apply && (sel_pd == TGT_PU)),
        .d_sw    (pu_code),
        .code    (pu_drv),
        .code_nb (pu_drv_nb)
    );

    zq_code_reg #(.W(PD_W)) u_pd_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_hw   (hw_apply && (pend_sel == TGT_PD)),
        .d_hw    (pend_pd),
        .we_sw   (sw_apply && (sel_pd == TGT_PD)),
        .d_sw    (pd_code),
        .code    (pd_drv),
        .code_nb (pd_drv_nb)
    );

    p_arm_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_ok |=> busy);
    p_refresh_completes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && refresh_evt && cal_en && !trig_rise) |=> !busy);
    p_cal_off_cancels_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |=> !busy);
    p_no_arm_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cal_en && hw_en)) |=> !busy);
    p_idle_refresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && refresh_evt && !sw_apply) |=> ($stable(pu_drv) && $stable(pd_drv)));
endmodule

// File: tb/test_zq_code_loader.sv
module test_zq_code_loader;
    localparam int PU_W = 5;
    localparam int PD_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cal_en = 1'b0, hw_en = 1'b0, hw_trig = 1'b0;
    logic            sw_en = 1'b0, sw_go = 1'b0, sel_pd = 1'b0, refresh_evt = 1'b0;
    logic [PU_W-1:0] pu_code = '0;
    logic [PD_W-1:0] pd_code = '0;
    logic [PU_W-1:0] pu_drv, pu_drv_nb;
    logic [PD_W-1:0] pd_drv, pd_drv_nb;
    logic            busy;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    zq_code_loader #(.PU_W(PU_W), .PD_W(PD_W)) i_zq_code_loader (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .hw_en(hw_en),
        .hw_trig(hw_trig), .sw_en(sw_en), .sw_go(sw_go), .sel_pd(sel_pd),
        .refresh_evt(refresh_evt), .pu_code(pu_code), .pd_code(pd_code),
        .pu_drv(pu_drv), .pu_drv_nb(pu_drv_nb), .pd_drv(pd_drv),
        .pd_drv_nb(pd_drv_nb), .busy(busy)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat_inc(input int v, input int w);
        int mx = (1 << w) - 1;
        return (v == mx) ? mx : v + 1;
    endfunction

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 pu", int'(pu_drv), 0);
        chk("R1 pu_nb", int'(pu_drv_nb), 1);
        chk("R1 pd", int'(pd_drv), 0);
        chk("R1 pd_nb", int'(pd_drv_nb), 1);
        chk("R1 busy", int'(busy), 0);
        rst_n = 1'b1;
        cal_en = 1'b1;
        step();

        // R7 / R9: sweep pull-up through the immediate path
        sw_en = 1'b1; sel_pd = 1'b0;
        for (int i = 0; i < 32; i++) begin
            pu_code = PU_W'(i); sw_go = 1'b1;
            step();
            chk("R7 pu", int'(pu_drv), i);
            chk("R9 pu_nb", int'(pu_drv_nb), sat_inc(i, PU_W));
        end
        sw_go = 1'b0;
        sel_pd = 1'b1;
        for (int j = 0; j < 16; j++) begin
            pd_code = PD_W'(j); sw_go = 1'b1;
            step();
            chk("R7 pd", int'(pd_drv), j);
            chk("R9 pd_nb", int'(pd_drv_nb), sat_inc(j, PD_W));
            chk("R7 pu untouched", int'(pu_drv), 31);
        end
        sw_go = 1'b0;

        // R8: one of the two bits missing
        pd_code = 4'd4; sw_en = 1'b1; sw_go = 1'b0;
        step();
        chk("R8 go low", int'(pd_drv), 15);
        sw_en = 1'b0; sw_go = 1'b1;
        step();
        chk("R8 en low", int'(pd_drv), 15);
        sw_go = 1'b0;

        // R12: hw path disabled
        hw_en = 1'b0; hw_trig = 1'b1;
        step();
        chk("R12 busy", int'(busy), 0);
        refresh_evt = 1'b1; step(); refresh_evt = 1'b0;
        chk("R12 pu", int'(pu_drv), 31);
        chk("R12 pd", int'(pd_drv), 15);
        hw_trig = 1'b0; step();

        // R2: arm and wait
        hw_en = 1'b1; sel_pd = 1'b0; pu_code = 5'd7; hw_trig = 1'b1;
        step();
        chk("R2 busy", int'(busy), 1);
        chk("R2 pu held", int'(pu_drv), 31);
        pu_code = 5'd9;
        step(); step();
        chk("R2 busy held", int'(busy), 1);
        chk("R2 pu still held", int'(pu_drv), 31);

        // R4: refresh commits snapshot
        refresh_evt = 1'b1; step(); refresh_evt = 1'b0;
        chk("R4 pu", int'(pu_drv), 7);
        chk("R4 pu_nb", int'(pu_drv_nb), 8);
        chk("R4 pd untouched", int'(pd_drv), 15);
        chk("R4 busy", int'(busy), 0);

        // R3: trigger held high does not re-arm
        step();
        chk("R3 busy", int'(busy), 0);
        refresh_evt = 1'b1; step(); refresh_evt = 1'b0;
        chk("R3 pu", int'(pu_drv), 7);

        // R6: re-arm replaces snapshot
        hw_trig = 1'b0; step();
        pu_code = 5'd3; hw_trig = 1'b1; step();
        chk("R6 busy", int'(busy), 1);
        hw_trig = 1'b0; step();
        sel_pd = 1'b1; pd_code = 4'd5; hw_trig = 1'b1; step();
        chk("R6 busy rearm", int'(busy), 1);
        hw_trig = 1'b0; refresh_evt = 1'b1; step(); refresh_evt = 1'b0;
        chk("R6 pd", int'(pd_drv), 5);
        chk("R6 pd_nb", int'(pd_drv_nb), 6);
        chk("R6 pu", int'(pu_drv), 7);
        chk("R6 busy", int'(busy), 0);

        // R5: refresh while idle
        pu_code = 5'd22; pd_code = 4'd2;
        refresh_evt = 1'b1; step(); refresh_evt = 1'b0;
        chk("R5 pu", int'(pu_drv), 7);
        chk("R5 pd", int'(pd_drv), 5);

        // R10: calibration enable low
        sel_pd = 1'b0; pu_code = 5'd12; hw_trig = 1'b1; step();
        chk("R10 armed", int'(busy), 1);
        hw_trig = 1'b0; cal_en = 1'b0; step();
        chk("R10 cancel", int'(busy), 0);
        cal_en = 1'b1; refresh_evt = 1'b1; step(); refresh_evt = 1'b0;
        chk("R10 no apply", int'(pu_drv), 7);
        cal_en = 1'b0; sw_en = 1'b1; sw_go = 1'b1; pu_code = 5'd13; step();
        chk("R10 sw ignored", int'(pu_drv), 7);
        sw_go = 1'b0; hw_trig = 1'b1; step();
        chk("R10 no arm", int'(busy), 0);
        hw_trig = 1'b0; cal_en = 1'b1; step();

        // R11: same-cycle collision
        sel_pd = 1'b0; pu_code = 5'd20; hw_trig = 1'b1; step();
        chk("R11 armed", int'(busy), 1);
        hw_trig = 1'b0; pu_code = 5'd25; sw_go = 1'b1; refresh_evt = 1'b1;
        step();
        sw_go = 1'b0; refresh_evt = 1'b0;
        chk("R11 pu", int'(pu_drv), 25);
        chk("R11 pu_nb", int'(pu_drv_nb), 26);
        chk("R11 busy", int'(busy), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule